// File: doc/BRIEF.md
# Compare and Capture Interval Timer

This block is a free-running up-counter that software starts and stops, with two compare channels and one capture channel. An internal divide-by-eight prescaler paces the counter, so the count moves once every eight input clocks while the run bit is set. Each compare channel flags a single-cycle request when the counter steps onto the value held in its register. The second channel can also fold the count back to zero, which turns the counter into a periodic interval timer.

An external pin is synchronized and watched for a programmable edge. When a qualifying edge arrives, the current count is latched into a read-only capture register. The same event raises a single-cycle external request. The control, compare and capture values are exposed as plain ports. Address decode and interrupt collection sit outside this block.

Top module: `cmpcap_timer`

## Requirements
- R1: After reset the count, the capture value, both compare registers, the control register and all three request outputs are zero, and the counter is stopped.
- R2: With control bit 0 (run) clear, the count holds its value, and the prescaler returns to its starting phase.
- R3: With run set, the count advances by one once every 8 clocks. After the clock edge that sets run, the count after n further edges is the start value plus floor(n/8), as long as no clear occurs.
- R4: A compare request (irq_cmp0 or irq_cmp1) is high for exactly the one cycle that follows the edge on which the count takes a value equal to that channel's compare register.
- R5: With control bit 1 (clear enable) set, a count tick taken while the count equals compare register 1 loads zero instead of count+1, so the period is cmp1+1 ticks. With the bit clear, the count passes that value and keeps rising.
- R6: cap_in passes through a two-flop synchronizer. A qualifying edge copies the count into capture_q on the second clock edge after the synchronized change, using the count value from before any update made on that same edge. capture_q holds between qualifying edges.
- R7: Every qualifying edge also produces a one-cycle pulse on irq_ext, in the cycle in which capture_q takes its new value.
- R8: Control bits 3:2 select the qualifying edge: 00 none, 01 rising, 10 falling, 11 both. An edge that is not selected changes neither capture_q nor irq_ext.
- R9: All eight control bits read back on ctrl_q. Bits 7:4 have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control write data: bit0 run, bit1 clear enable, bits3:2 edge mode |
| ctrl_q | output | 8 | Control register readback |
| cmp0_we | input | 1 | Write strobe for compare register 0 |
| cmp1_we | input | 1 | Write strobe for compare register 1 |
| cmp_wdata | input | 16 | Compare write data |
| cmp0_q | output | 16 | Compare register 0 readback |
| cmp1_q | output | 16 | Compare register 1 readback |
| cap_in | input | 1 | External capture and request input (asynchronous) |
| count_q | output | 16 | Current count |
| capture_q | output | 16 | Last captured count |
| irq_cmp0 | output | 1 | Compare 0 match request |
| irq_cmp1 | output | 1 | Compare 1 match request |
| irq_ext | output | 1 | External edge request |

## Verification
A table of runs varies the clear enable, the second compare value and the run length. Free counting and several interval periods, including a zero period, therefore land on different final counts. A monitored run records the edge index and number of each compare pulse, which separates a pulse on the matching tick from one that repeats or fires early. For the capture channel, rising and falling inputs are applied under every edge mode, with the count moved between trials so that a wrongly taken capture shows up as a changed value.

// File: rtl/cmpcap_timer.sv
module cmpcap_timer #(
  parameter int W        = 16,
  parameter int PRE_BITS = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic [7:0]   ctrl_wdata,
  output logic [7:0]   ctrl_q,
  input  logic         cmp0_we,
  input  logic         cmp1_we,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] cmp0_q,
  output logic [W-1:0] cmp1_q,
  input  logic         cap_in,
  output logic [W-1:0] count_q,
  output logic [W-1:0] capture_q,
  output logic         irq_cmp0,
  output logic         irq_cmp1,
  output logic         irq_ext
);

  logic [PRE_BITS-1:0] presc;
  logic [W-1:0]        count_nxt;
  logic [2:0]          sync;
  logic                run, clr_en, tick, rise, fall, edge_hit;
  logic [1:0]          mode;

  assign run    = ctrl_q[0];
  assign clr_en = ctrl_q[1];
  assign mode   = ctrl_q[3:2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp0_q <= '0;
      cmp1_q <= '0;
    end else begin
      if (cmp0_we) cmp0_q <= cmp_wdata;
      if (cmp1_we) cmp1_q <= cmp_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   presc <= '0;
    else if (run) presc <= presc + 1'b1;
    else          presc <= '0;

  assign tick      = run && (&presc);
  assign count_nxt = (clr_en && count_q == cmp1_q) ? '0 : count_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count_q  <= '0;
      irq_cmp0 <= 1'b0;
      irq_cmp1 <= 1'b0;
    end else begin
      if (tick) count_q <= count_nxt;
      irq_cmp0 <= tick && (count_nxt == cmp0_q);
      irq_cmp1 <= tick && (count_nxt == cmp1_q);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], cap_in};

  assign rise     = sync[1] & ~sync[2];
  assign fall     = ~sync[1] & sync[2];
  assign edge_hit = (mode[0] & rise) | (mode[1] & fall);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      capture_q <= '0;
      irq_ext   <= 1'b0;
    end else begin
      if (edge_hit) capture_q <= count_q;
      irq_ext <= edge_hit;
    end

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count_q));

  // R4
  irq0_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp0 |=> !irq_cmp0);

  // R4
  irq1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp1 |=> !irq_cmp1);

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr_en && count_q == cmp1_q) |=> count_q == '0);

  // R6
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> capture_q == $past(count_q));

  // R7
  ext_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ext |-> !$stable(sync[2]));

endmodule

// File: tb/cmpcap_timer_tb_top.sv
module cmpcap_timer_tb_top;
  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, cmp0_we = 0, cmp1_we = 0, cap_in = 0;
  logic [7:0]  ctrl_wdata = 0, ctrl_q;
  logic [15:0] cmp_wdata = 0, cmp0_q, cmp1_q, count_q, capture_q;
  logic irq_cmp0, irq_cmp1, irq_ext;
  int errors = 0, checks = 0;
  int p0, p1, pe, first0, first1;

  always #10 clk = ~clk;

  cmpcap_timer dut_i (.clk, .rst_n, .ctrl_we, .ctrl_wdata, .ctrl_q, .cmp0_we, .cmp1_we,
    .cmp_wdata, .cmp0_q, .cmp1_q, .cap_in, .count_q, .capture_q, .irq_cmp0, .irq_cmp1, .irq_ext);

  // {ctrl clear bit, cmp1, run edges, expected count}
  localparam int VEC[6][4] = '{
    '{0, 3, 40, 5}, '{2, 3, 40, 1}, '{2, 2, 100, 0},
    '{2, 0, 24, 0}, '{0, 0, 24, 3}, '{2, 6, 72, 2}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1; ctrl_wdata = v;
    @(posedge clk); @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic wr_cmp(input int ch, input logic [15:0] v);
    cmp_wdata = v; cmp0_we = (ch == 0); cmp1_we = (ch == 1);
    @(posedge clk); @(negedge clk);
    cmp0_we = 0; cmp1_we = 0;
  endtask

  task automatic run_for(input int n, input logic [7:0] c);
    p0 = 0; p1 = 0; first0 = -1; first1 = -1;
    wr_ctrl(c | 8'h01);
    for (int i = 1; i <= n; i++) begin
      if (i == n) wr_ctrl(c & 8'hFE);
      else @(negedge clk);
      if (irq_cmp0) begin p0++; if (first0 < 0) first0 = i; end
      if (irq_cmp1) begin p1++; if (first1 < 0) first1 = i; end
    end
  endtask

  task automatic drive_ext(input logic v);
    pe = 0;
    cap_in = v;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (irq_ext) pe++;
    end
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1
    chk(count_q == 0 && capture_q == 0 && ctrl_q == 0, "R1 reset regs", count_q, 0);
    chk(cmp0_q == 0 && cmp1_q == 0, "R1 reset compare", cmp1_q, 0);
    chk(!irq_cmp0 && !irq_cmp1 && !irq_ext, "R1 reset requests", irq_cmp0, 0);
    repeat (20) @(negedge clk);
    chk(count_q == 0, "R2 stopped after reset", count_q, 0);

    for (int k = 0; k < 6; k++) begin
      do_reset();
      wr_cmp(0, 16'hFFF0);
      wr_cmp(1, 16'(VEC[k][1]));
      run_for(VEC[k][2], 8'(VEC[k][0]));
      chk(count_q == 16'(VEC[k][3]), "R3/R5 table run", count_q, VEC[k][3]);
      repeat (12) @(negedge clk);
      chk(count_q == 16'(VEC[k][3]), "R2 hold after stop", count_q, VEC[k][3]);
    end

    // R4 free running compares
    do_reset();
    wr_cmp(0, 2); wr_cmp(1, 3);
    chk(cmp0_q == 2 && cmp1_q == 3, "R4 compare readback", cmp1_q, 3);
    run_for(40, 8'h00);
    chk(p0 == 1 && first0 == 16, "R4 irq_cmp0 edge", first0, 16);
    chk(p1 == 1 && first1 == 24, "R4 irq_cmp1 edge", first1, 24);

    // R5 interval with requests
    do_reset();
    wr_cmp(0, 0); wr_cmp(1, 1);
    run_for(40, 8'h02);
    chk(p1 == 3 && first1 == 8, "R5 interval irq_cmp1 count", p1, 3);
    chk(p0 == 2 && first0 == 16, "R5 wrap irq_cmp0 count", p0, 2);
    chk(count_q == 1, "R5 interval final count", count_q, 1);

    // R9
    do_reset();
    wr_ctrl(8'hF0);
    chk(ctrl_q == 8'hF0, "R9 control readback", ctrl_q, 8'hF0);
    repeat (16) @(negedge clk);
    chk(count_q == 0, "R9 upper bits no run", count_q, 0);

    // R6 R7 R8 capture modes
    do_reset();
    run_for(40, 8'h00);
    wr_ctrl(8'h04);
    drive_ext(1);
    chk(capture_q == 5, "R6 rising capture", capture_q, 5);
    chk(pe == 1, "R7 rising request", pe, 1);
    run_for(16, 8'h04);
    drive_ext(0);
    chk(capture_q == 5 && pe == 0, "R8 falling ignored in rising mode", capture_q, 5);
    wr_ctrl(8'h08);
    drive_ext(1);
    chk(capture_q == 5 && pe == 0, "R8 rising ignored in falling mode", capture_q, 5);
    drive_ext(0);
    chk(capture_q == 7 && pe == 1, "R8 falling mode capture", capture_q, 7);
    run_for(8, 8'h0C);
    drive_ext(1);
    chk(capture_q == 8 && pe == 1, "R8 both mode rising", capture_q, 8);
    run_for(8, 8'h0C);
    drive_ext(0);
    chk(capture_q == 9 && pe == 1, "R8 both mode falling", capture_q, 9);
    run_for(8, 8'h00);
    drive_ext(1);
    chk(capture_q == 9 && pe == 0, "R8 mode none ignores edge", capture_q, 9);
    drive_ext(0);
    chk(capture_q == 9 && pe == 0, "R6 capture held", capture_q, 9);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule